// File: doc/BRIEF.md
# Sectored Decoded Instruction Cache

This block keeps already-decoded instruction words close to the fetch stage. When a fetch hits, the pipeline can skip both the instruction-memory read and the decode step. The storage holds 512 bytes of decoded words, arranged as 256 slots of 16 bits. The slots are grouped into 32 directly mapped sectors. A sector holds two lines of four slots, and the whole sector is covered by one tag. Every slot has its own valid bit, so a single decoded word can be installed or looked up without its neighbours being present.

The fetch side presents an instruction-word address on the lookup port every cycle. The hit flag and the stored word come back combinationally in the same cycle. After decode, the decoder offers the word on the fill port together with a flag that says whether its decoded form fits a slot. Words flagged as not fitting never allocate. A synchronous invalidate-all input, and reset, empty the cache in one cycle.

Top module: `dic_top`

## Requirements
- R1: After a cycle with rst_n low, no lookup address hits until a new fill is made.
- R2: A lookup hits in the same cycle, combinationally, when the sector tag equals address bits [15:8] and the valid bit of the addressed slot is set. lk_data then equals the last word written to that slot.
- R3: A fill with fill_cacheable low changes nothing. A slot that was valid keeps its old word, and a slot that was empty stays a miss.
- R4: Valid bits are per slot. Address bits [1:0] select the slot within a line and bit [2] selects the line. Filling one slot leaves the other slots of the same line and sector missing.
- R5: The two lines of a sector share one tag. Fills with the same tag to both lines leave both lines hitting.
- R6: A cacheable fill whose tag differs from the stored tag of its sector does three things: it installs the new tag, clears every other valid bit of that sector, and makes only the filled slot valid.
- R7: When inval_all is high at a clock edge, every valid bit is cleared at that edge. A fill offered in the same cycle is dropped.
- R8: A cacheable fill becomes visible to lookups from the cycle after its clock edge. A lookup in the fill cycle itself sees the state from before the fill.
- R9: Sectors are selected by address bits [7:3]. A fill to one sector does not disturb the contents of any other sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; clears all valid bits |
| inval_all | input | 1 | Synchronous clear of every valid bit |
| lk_addr | input | 16 | Lookup instruction-word address |
| lk_hit | output | 1 | Lookup hit, same cycle |
| lk_data | output | 16 | Decoded word of the addressed slot; meaningful when lk_hit is high |
| fill_en | input | 1 | Fill request strobe |
| fill_addr | input | 16 | Fill instruction-word address |
| fill_data | input | 16 | Decoded word to store |
| fill_cacheable | input | 1 | High when the decoded word fits a slot |

## Verification
A wrong valid bit or tag becomes visible at the ports the first time the affected address is looked up. lk_hit is combinational, so the error appears in that same cycle: a slot that should be empty reports a hit, or a filled slot reports a miss. A wrong word in the data array shows up only when the slot hits, as a wrong lk_data value. For that reason each fill is read back in the cycle after it. Its neighbouring slots, its other line, and other sectors are probed at the same time, so that state which leaked from one slot or sector into another gets exposed.

// File: rtl/dic_pkg.sv
// Shared definitions for the sectored decoded-instruction cache.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package dic_pkg;

    // Action the tag store takes for the fill offered this cycle.
    typedef enum logic [1:0] {
        FILL_NONE    = 2'd0,  // no write (idle, uncacheable or invalidated)
        FILL_MERGE   = 2'd1,  // tag matches: set one more valid bit
        FILL_REPLACE = 2'd2   // tag differs: new tag, sector cleared, one bit set
    } fill_act_e;

endpackage

// File: rtl/dic_addr_split.sv
// Splits an instruction-word address into tag, sector index and slot
// position within the sector (line bits above slot bits).
// Assumes: power-of-two slots per line, lines per sector and sectors.
module dic_addr_split #(
    parameter int ADDR_W           = 16,
    parameter int SLOTS_PER_LINE   = 4,
    parameter int LINES_PER_SECTOR = 2,
    parameter int SECTORS          = 32,
    localparam int OFF_BITS  = $clog2(SLOTS_PER_LINE * LINES_PER_SECTOR),
    localparam int SECT_BITS = $clog2(SECTORS),
    localparam int TAG_W     = ADDR_W - OFF_BITS - SECT_BITS
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [TAG_W-1:0]     tag,
    output logic [SECT_BITS-1:0] sect,
    output logic [OFF_BITS-1:0]  slot
);

    // Field extraction: offset lowest, index next, tag on top.
    always_comb begin
        slot = addr[OFF_BITS-1:0];
        sect = addr[OFF_BITS +: SECT_BITS];
        tag  = addr[ADDR_W-1 -: TAG_W];
    end

endmodule

// File: rtl/dic_tag_store.sv
// Holds one tag per sector and one valid bit per slot. Produces the
// lookup hit and decides the fill action for the data array.
// Assumes: one fill and one lookup per cycle; invalidate wins over fill.
module dic_tag_store
    import dic_pkg::*;
#(
    parameter int TAG_W     = 8,
    parameter int SECT_BITS = 5,
    parameter int OFF_BITS  = 3,
    localparam int SECTORS  = 1 << SECT_BITS,
    localparam int SPS      = 1 << OFF_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 inval_all,
    input  logic                 fill_en,
    input  logic                 fill_cacheable,
    input  logic [TAG_W-1:0]     fill_tag,
    input  logic [SECT_BITS-1:0] fill_sect,
    input  logic [OFF_BITS-1:0]  fill_slot,
    input  logic [TAG_W-1:0]     lk_tag,
    input  logic [SECT_BITS-1:0] lk_sect,
    input  logic [OFF_BITS-1:0]  lk_slot,
    output logic                 lk_hit,
    output fill_act_e            fill_act
);

    logic [TAG_W-1:0] tag_a [SECTORS];
    logic [SPS-1:0]   vld_a [SECTORS];
    logic [SPS-1:0]   fill_onehot;

    // Fill decision: gate on cacheable and invalidate, then compare tags.
    always_comb begin
        fill_onehot = SPS'(1) << fill_slot;
        if (!fill_en || !fill_cacheable || inval_all)
            fill_act = FILL_NONE;
        else if (tag_a[fill_sect] == fill_tag)
            fill_act = FILL_MERGE;
        else
            fill_act = FILL_REPLACE;
    end

    for (genvar s = 0; s < SECTORS; s++) begin : g_sect
        logic [TAG_W-1:0] tag_r;
        logic [SPS-1:0]   vld_r;
        logic             sel;

        assign sel      = (fill_sect == SECT_BITS'(s));
        assign tag_a[s] = tag_r;
        assign vld_a[s] = vld_r;

        // Per-sector tag and valid update: reset/invalidate, merge or replace.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_r <= '0;
                vld_r <= '0;
            end else if (inval_all) begin
                vld_r <= '0;
            end else if (sel && fill_act == FILL_MERGE) begin
                vld_r <= vld_r | fill_onehot;
            end else if (sel && fill_act == FILL_REPLACE) begin
                tag_r <= fill_tag;
                vld_r <= fill_onehot;
            end
        end
    end

    // Lookup: hit needs both the sector tag match and the slot valid bit.
    always_comb begin
        lk_hit = (tag_a[lk_sect] == lk_tag) && vld_a[lk_sect][lk_slot];
    end

endmodule

// File: rtl/dic_data_store.sv
// Decoded-word array, one entry per slot, written on accepted fills and
// read asynchronously for the lookup port.
// Assumes: contents need no reset; validity is tracked by the tag store.
module dic_data_store #(
    parameter int SLOT_W    = 16,
    parameter int SECT_BITS = 5,
    parameter int OFF_BITS  = 3,
    localparam int IDX_W    = SECT_BITS + OFF_BITS,
    localparam int ENTRIES  = 1 << IDX_W
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [SECT_BITS-1:0] wr_sect,
    input  logic [OFF_BITS-1:0]  wr_slot,
    input  logic [SLOT_W-1:0]    wr_data,
    input  logic [SECT_BITS-1:0] rd_sect,
    input  logic [OFF_BITS-1:0]  rd_slot,
    output logic [SLOT_W-1:0]    rd_data
);

    logic [SLOT_W-1:0] mem [ENTRIES];

    // Write port: one slot per cycle.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[{wr_sect, wr_slot}] <= wr_data;
    end

    // Read port: combinational for same-cycle lookup.
    always_comb begin
        rd_data = mem[{rd_sect, rd_slot}];
    end

endmodule

// File: rtl/dic_top.sv
// Sectored decoded-instruction cache top: direct-mapped sectors, shared
// sector tag, per-slot valid, fill gated by the cacheable classification.
// Assumes: word addresses; lookup result used in the cycle it is asked.
module dic_top
    import dic_pkg::*;
#(
    parameter int ADDR_W           = 16,
    parameter int SLOT_W           = 16,
    parameter int SLOTS_PER_LINE   = 4,
    parameter int LINES_PER_SECTOR = 2,
    parameter int SECTORS          = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inval_all,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [SLOT_W-1:0] lk_data,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [SLOT_W-1:0] fill_data,
    input  logic              fill_cacheable
);

    localparam int OFF_BITS  = $clog2(SLOTS_PER_LINE * LINES_PER_SECTOR);
    localparam int SECT_BITS = $clog2(SECTORS);
    localparam int TAG_W     = ADDR_W - OFF_BITS - SECT_BITS;

    logic [TAG_W-1:0]     lk_tag,  fill_tag;
    logic [SECT_BITS-1:0] lk_sect, fill_sect;
    logic [OFF_BITS-1:0]  lk_slot, fill_slot;
    fill_act_e            fill_act;

    dic_addr_split #(
        .ADDR_W(ADDR_W), .SLOTS_PER_LINE(SLOTS_PER_LINE),
        .LINES_PER_SECTOR(LINES_PER_SECTOR), .SECTORS(SECTORS)
    ) u_lk_split (
        .addr(lk_addr), .tag(lk_tag), .sect(lk_sect), .slot(lk_slot)
    );

    dic_addr_split #(
        .ADDR_W(ADDR_W), .SLOTS_PER_LINE(SLOTS_PER_LINE),
        .LINES_PER_SECTOR(LINES_PER_SECTOR), .SECTORS(SECTORS)
    ) u_fill_split (
        .addr(fill_addr), .tag(fill_tag), .sect(fill_sect), .slot(fill_slot)
    );

    dic_tag_store #(
        .TAG_W(TAG_W), .SECT_BITS(SECT_BITS), .OFF_BITS(OFF_BITS)
    ) u_tags (
        .clk(clk), .rst_n(rst_n), .inval_all(inval_all),
        .fill_en(fill_en), .fill_cacheable(fill_cacheable),
        .fill_tag(fill_tag), .fill_sect(fill_sect), .fill_slot(fill_slot),
        .lk_tag(lk_tag), .lk_sect(lk_sect), .lk_slot(lk_slot),
        .lk_hit(lk_hit), .fill_act(fill_act)
    );

    dic_data_store #(
        .SLOT_W(SLOT_W), .SECT_BITS(SECT_BITS), .OFF_BITS(OFF_BITS)
    ) u_data (
        .clk(clk), .wr_en(fill_act != FILL_NONE),
        .wr_sect(fill_sect), .wr_slot(fill_slot), .wr_data(fill_data),
        .rd_sect(lk_sect), .rd_slot(lk_slot), .rd_data(lk_data)
    );

endmodule

// File: rtl/dic_checker.sv
// Port-level temporal checks for dic_top, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module dic_checker #(
    parameter int ADDR_W = 16,
    parameter int SLOT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inval_all,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              lk_hit,
    input logic [SLOT_W-1:0] lk_data,
    input logic              fill_en,
    input logic [ADDR_W-1:0] fill_addr,
    input logic [SLOT_W-1:0] fill_data,
    input logic              fill_cacheable
);

    // First cycle out of reset: the cache is empty.
    p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !lk_hit);

    // Hit flag is always a known value once running.
    p_hit_known_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(lk_hit));

    // An accepted fill is visible, with its word, from the next cycle.
    p_fill_visible_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && fill_cacheable && !inval_all) |=>
        (lk_addr != $past(fill_addr) || (lk_hit && lk_data == $past(fill_data))));

    // An uncacheable fill leaves the looked-up slot as it was.
    p_uncacheable_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !fill_cacheable && !inval_all && lk_addr == fill_addr) |=>
        (!$stable(lk_addr) || ($stable(lk_hit) && (!lk_hit || $stable(lk_data)))));

    // Invalidate-all leaves nothing valid, even with a fill in the same cycle.
    p_inval_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all |=> !lk_hit);

endmodule

bind dic_top dic_checker #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .inval_all(inval_all),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
    .fill_en(fill_en), .fill_addr(fill_addr), .fill_data(fill_data),
    .fill_cacheable(fill_cacheable)
);

// File: tb/sim_dic_top.sv
`timescale 1ns/1ps
// Directed bench for dic_top: one task per scenario, each self-checking.
module sim_dic_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inval_all = 1'b0;
    logic [15:0] lk_addr = '0;
    logic        lk_hit;
    logic [15:0] lk_data;
    logic        fill_en = 1'b0;
    logic [15:0] fill_addr = '0;
    logic [15:0] fill_data = '0;
    logic        fill_cacheable = 1'b0;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    dic_top u0 (
        .clk(clk), .rst_n(rst_n), .inval_all(inval_all),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
        .fill_en(fill_en), .fill_addr(fill_addr), .fill_data(fill_data),
        .fill_cacheable(fill_cacheable)
    );

    // Address layout: tag [15:8], sector [7:3], line [2], slot [1:0].
    function automatic logic [15:0] mk(int tg, int sc, int ln, int sl);
        return {tg[7:0], sc[4:0], ln[0], sl[1:0]};
    endfunction

    // Compare current lookup outputs against expectation.
    task automatic compare(string req, bit exp_hit, logic [15:0] exp_d);
        checks++;
        if (lk_hit !== exp_hit || (exp_hit && lk_data !== exp_d)) begin
            errors++;
            $display("FAIL %s addr=%h hit=%b data=%h expected hit=%b data=%h",
                     req, lk_addr, lk_hit, lk_data, exp_hit, exp_d);
        end
    endtask

    // Lookup at mid-cycle and check.
    task automatic look(string req, logic [15:0] a, bit exp_hit, logic [15:0] exp_d);
        @(negedge clk);
        lk_addr = a;
        #1;
        compare(req, exp_hit, exp_d);
    endtask

    // One-cycle fill request.
    task automatic fill(logic [15:0] a, logic [15:0] d, bit cach);
        @(negedge clk);
        fill_en = 1'b1; fill_addr = a; fill_data = d; fill_cacheable = cach;
        @(posedge clk);
        #1;
        fill_en = 1'b0; fill_cacheable = 1'b0;
    endtask

    task automatic t_reset_state();
        look("R1", mk(0, 0, 0, 0), 1'b0, '0);
        look("R1", mk(8'hff, 31, 1, 3), 1'b0, '0);
    endtask

    // Fill timing: miss during the fill cycle, hit right after (R2, R8).
    task automatic t_fill_timing();
        @(negedge clk);
        lk_addr = mk(3, 5, 0, 0);
        fill_en = 1'b1; fill_addr = mk(3, 5, 0, 0);
        fill_data = 16'hA5A0; fill_cacheable = 1'b1;
        #1;
        compare("R8", 1'b0, '0);
        @(posedge clk);
        #1;
        fill_en = 1'b0; fill_cacheable = 1'b0;
        compare("R8", 1'b1, 16'hA5A0);
        look("R2", mk(3, 5, 0, 0), 1'b1, 16'hA5A0);
    endtask

    task automatic t_slot_indep();
        look("R4", mk(3, 5, 0, 1), 1'b0, '0);
        look("R4", mk(3, 5, 1, 0), 1'b0, '0);
        look("R2", mk(4, 5, 0, 0), 1'b0, '0);   // wrong tag, valid slot
    endtask

    task automatic t_shared_tag();
        fill(mk(3, 5, 1, 2), 16'h1234, 1'b1);
        look("R5", mk(3, 5, 1, 2), 1'b1, 16'h1234);
        look("R5", mk(3, 5, 0, 0), 1'b1, 16'hA5A0);
    endtask

    task automatic t_replace();
        fill(mk(9, 5, 0, 3), 16'hBEEF, 1'b1);
        look("R6", mk(9, 5, 0, 3), 1'b1, 16'hBEEF);
        look("R6", mk(3, 5, 0, 0), 1'b0, '0);
        look("R6", mk(3, 5, 1, 2), 1'b0, '0);
        look("R6", mk(9, 5, 0, 0), 1'b0, '0);   // new tag, old slot cleared
    endtask

    task automatic t_uncacheable();
        fill(mk(9, 5, 0, 3), 16'h0BAD, 1'b0);
        look("R3", mk(9, 5, 0, 3), 1'b1, 16'hBEEF);
        fill(mk(9, 5, 0, 1), 16'h0BAD, 1'b0);
        look("R3", mk(9, 5, 0, 1), 1'b0, '0);
        fill(mk(7, 5, 0, 3), 16'h0BAD, 1'b0);  // other tag: no replacement
        look("R3", mk(9, 5, 0, 3), 1'b1, 16'hBEEF);
    endtask

    task automatic t_sectors();
        fill(mk(1, 0, 0, 0), 16'h1111, 1'b1);
        fill(mk(2, 31, 1, 3), 16'h2222, 1'b1);
        look("R9", mk(1, 0, 0, 0), 1'b1, 16'h1111);
        look("R9", mk(2, 31, 1, 3), 1'b1, 16'h2222);
        look("R9", mk(9, 5, 0, 3), 1'b1, 16'hBEEF);
        look("R9", mk(1, 1, 0, 0), 1'b0, '0);
    endtask

    task automatic t_invalidate();
        @(negedge clk);
        inval_all = 1'b1;
        fill_en = 1'b1; fill_addr = mk(6, 6, 0, 0);
        fill_data = 16'h6666; fill_cacheable = 1'b1;
        @(posedge clk);
        #1;
        inval_all = 1'b0; fill_en = 1'b0; fill_cacheable = 1'b0;
        look("R7", mk(1, 0, 0, 0), 1'b0, '0);
        look("R7", mk(2, 31, 1, 3), 1'b0, '0);
        look("R7", mk(9, 5, 0, 3), 1'b0, '0);
        look("R7", mk(6, 6, 0, 0), 1'b0, '0);
        fill(mk(6, 6, 0, 0), 16'h6767, 1'b1);
        look("R7", mk(6, 6, 0, 0), 1'b1, 16'h6767);
    endtask

    task automatic t_reset_clears();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        look("R1", mk(6, 6, 0, 0), 1'b0, '0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // Scenario sequence.
    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset_state();
        t_fill_timing();
        t_slot_indep();
        t_shared_tag();
        t_replace();
        t_uncacheable();
        t_sectors();
        t_invalidate();
        t_reset_clears();
        finish_run();
    end

endmodule